// File: doc/BRIEF.md
# Dual-Channel Symmetric FIR with Block-Atomic Coefficient Loading

This block runs two independent linear-phase FIR filters, one for each audio channel. They share a single sample strobe. Each filter has 12 taps with even symmetry, so six signed 8-bit coefficients define it: coefficient k weights both tap k and tap 11−k. The input samples are signed, and the two channels filter their own sample streams in parallel.

Coefficients arrive over a simple control write port. Each write carries a 16-bit address and a 16-bit data word, and only the low byte of the data word is used. Each channel has its own address and a fixed byte order, highest coefficient first. The second channel's block also starts with a three-byte fixed preamble that is checked and then thrown away. Bytes are collected in a shadow bank. The filter's working coefficients change in one cycle, and only when the last byte of a complete block arrives. A half-sent block therefore never reaches the datapath.

Top module: `dfir_dual`

## Requirements
- R1: After reset, `out_a`, `out_b`, `out_valid` and `preamble_err` are 0, and every working coefficient is 0, so any input produces an output of 0.
- R2: Channel A coefficients are written at address 0x0001 as six bytes in the order c5, c4, c3, c2, c1, c0.
- R3: Channel B coefficients are written at address 0x0005 as nine bytes: the preamble 0x04, 0x40, 0x00, then c5 down to c0.
- R4: Only `wr_data[7:0]` carries a coefficient or preamble byte. `wr_data[15:8]` has no effect.
- R5: Until a channel's block is complete, its working coefficients and its filter output stay as they were, even while samples flow.
- R6: A write to the other channel's address throws away any partly received block on a channel, and that channel's next write starts a new block.
- R7: A preamble byte with the wrong value raises `preamble_err` for one cycle and restarts channel B's sequence. The byte is not stored.
- R8: Each output equals sum over k=0..5 of c[k]·(x[n−k] + x[n−11+k]), in signed two's complement. An impulse therefore yields c0..c5 followed by c5..c0.
- R9: `out_valid` is high for exactly one cycle, two clock edges after the edge that captured `smp_valid`. Between updates, `out_a` and `out_b` hold their values.
- R10: Writes to any address other than the two channel addresses are ignored. They neither advance nor cancel a block in progress.
- R11: Samples captured after the edge that takes in a block's last byte are filtered with the new coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 16 | Control write address |
| wr_data | input | 16 | Control write data; the low byte is used |
| smp_valid | input | 1 | Sample strobe shared by both channels |
| smp_in_a | input | 12 | Signed input sample, channel A |
| smp_in_b | input | 12 | Signed input sample, channel B |
| out_valid | output | 1 | Filtered result update strobe |
| out_a | output | 24 | Signed filter output, channel A |
| out_b | output | 24 | Signed filter output, channel B |
| preamble_err | output | 1 | One-cycle flag for a wrong preamble byte |

## Verification
Some rules hold on every cycle, and the assertions check those. The working coefficient banks change only on the cycle after a write to their own channel's address. The error flag rises only after a channel B write. The output strobe always lags the sample strobe by two edges, and the outputs hold steady between strobes. Other behaviour depends on a whole sequence of events, so only the bench's scenarios can show it: the byte order within a block, that the preamble is thrown away, the restart after an interrupted or corrupted block, that the upper byte is ignored, and the exact symmetric impulse and mixed-signal responses. The bench compares these against its own model of the filter, which it updates only when it has sent a full block.

// File: rtl/dfir_pkg.sv
package dfir_pkg;

   localparam int BYTE_W  = 8;
   localparam int PRE_MAX = 4;

   // Returns the preamble byte expected at position idx of a len-byte sequence.
   // The first byte sent sits in the most significant used byte of seq.
   function automatic logic [BYTE_W-1:0] pick_byte(
      input logic [BYTE_W*PRE_MAX-1:0] seq,
      input int                        len,
      input int                        idx
   );
      logic [BYTE_W-1:0] r;
      r = '0;
      for (int i = 0; i < PRE_MAX; i++) begin
         if (i == len - 1 - idx) r = seq[i*BYTE_W +: BYTE_W];
      end
      return r;
   endfunction

endpackage

// File: rtl/dfir_coef_loader.sv
module dfir_coef_loader #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int COEF_W     = 8,
   parameter int HALF       = 6,
   parameter logic [ADDR_W-1:0] MY_ADDR    = 16'h0001,
   parameter logic [ADDR_W-1:0] OTHER_ADDR = 16'h0005,
   parameter int PRE_LEN    = 0,
   parameter logic [dfir_pkg::BYTE_W*dfir_pkg::PRE_MAX-1:0] PRE_SEQ = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [HALF*COEF_W-1:0]   act_bank,
   output logic                     pre_err
);
   import dfir_pkg::*;

   localparam int BLK_LEN = PRE_LEN + HALF;
   localparam int CNT_W   = $clog2(BLK_LEN + 1);
   localparam int IDX_W   = (HALF > 1) ? $clog2(HALF) : 1;

   if (PRE_LEN > PRE_MAX) begin : g_bad_pre
      $error("dfir_coef_loader: PRE_LEN exceeds PRE_MAX");
   end
   if (COEF_W > DATA_W) begin : g_bad_coef
      $error("dfir_coef_loader: COEF_W wider than DATA_W");
   end

   logic              hit, abort_blk, last;
   logic              in_pre, pre_ok;
   logic [CNT_W-1:0]  cnt, cidx;
   logic [COEF_W-1:0] byte_v;
   logic [COEF_W-1:0] shadow [HALF];
   logic [COEF_W-1:0] act    [HALF];

   assign hit       = wr_en && (wr_addr == MY_ADDR);
   assign abort_blk = wr_en && (wr_addr == OTHER_ADDR);
   assign byte_v    = wr_data[COEF_W-1:0];
   assign last      = (cnt == CNT_W'(BLK_LEN - 1));
   // Coefficient slot for the current byte: highest index arrives first.
   assign cidx      = CNT_W'(BLK_LEN - 1) - cnt;

   // Variant choice: a channel with a preamble checks it, others skip straight to data.
   if (PRE_LEN > 0) begin : g_pre
      logic [BYTE_W-1:0] pre_exp;
      assign in_pre  = (cnt < CNT_W'(PRE_LEN));
      assign pre_exp = pick_byte(PRE_SEQ, PRE_LEN, int'(cnt));
      assign pre_ok  = (wr_data[BYTE_W-1:0] == pre_exp);
   end else begin : g_nopre
      assign in_pre  = 1'b0;
      assign pre_ok  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         pre_err <= 1'b0;
         for (int i = 0; i < HALF; i++) begin
            shadow[i] <= '0;
            act[i]    <= '0;
         end
      end else begin
         pre_err <= 1'b0;
         if (abort_blk) begin
            cnt <= '0;
         end else if (hit) begin
            if (in_pre) begin
               if (pre_ok) begin
                  cnt <= cnt + 1'b1;
               end else begin
                  cnt     <= '0;
                  pre_err <= 1'b1;
               end
            end else begin
               shadow[cidx[IDX_W-1:0]] <= byte_v;
               if (last) begin
                  cnt <= '0;
                  for (int i = 0; i < HALF; i++) begin
                     act[i] <= (i == 0) ? byte_v : shadow[i];
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   for (genvar g = 0; g < HALF; g++) begin : g_flat
      assign act_bank[g*COEF_W +: COEF_W] = act[g];
   end

endmodule

// File: rtl/dfir_sym_fir.sv
module dfir_sym_fir #(
   parameter int SAMPLE_W = 12,
   parameter int COEF_W   = 8,
   parameter int TAPS     = 12,
   parameter int OUT_W    = 24
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             smp_valid,
   input  logic signed [SAMPLE_W-1:0]       smp_in,
   input  logic [(TAPS/2)*COEF_W-1:0]       coef_bank,
   output logic                             out_valid,
   output logic signed [OUT_W-1:0]          out_y
);
   localparam int HALF   = TAPS / 2;
   localparam int PA_W   = SAMPLE_W + 1;
   localparam int PROD_W = PA_W + COEF_W;

   if (TAPS % 2 != 0 || TAPS < 2) begin : g_bad_taps
      $error("dfir_sym_fir: TAPS must be even and at least 2");
   end
   if (OUT_W < PROD_W + $clog2(HALF)) begin : g_bad_out
      $error("dfir_sym_fir: OUT_W too narrow for the accumulated sum");
   end

   logic signed [SAMPLE_W-1:0] dline [TAPS];
   logic signed [PROD_W-1:0]   prod  [HALF];
   logic signed [OUT_W-1:0]    acc;
   logic                       vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TAPS; i++) dline[i] <= '0;
      end else if (smp_valid) begin
         dline[0] <= smp_in;
         for (int i = 1; i < TAPS; i++) dline[i] <= dline[i-1];
      end
   end

   // Symmetric fold: the pair of taps sharing a coefficient is added first.
   for (genvar k = 0; k < HALF; k++) begin : g_pair
      logic signed [PA_W-1:0]   pa;
      logic signed [COEF_W-1:0] cf;
      assign pa      = PA_W'(dline[k]) + PA_W'(dline[TAPS-1-k]);
      assign cf      = coef_bank[k*COEF_W +: COEF_W];
      assign prod[k] = PROD_W'(pa) * PROD_W'(cf);
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < HALF; k++) acc = acc + OUT_W'(prod[k]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         out_valid <= 1'b0;
         out_y     <= '0;
      end else begin
         vld_q     <= smp_valid;
         out_valid <= vld_q;
         if (vld_q) out_y <= acc;
      end
   end

endmodule

// File: rtl/dfir_dual.sv
module dfir_dual #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int COEF_W   = 8,
   parameter int SAMPLE_W = 12,
   parameter int TAPS     = 12,
   parameter logic [ADDR_W-1:0] ADDR_A = 16'h0001,
   parameter logic [ADDR_W-1:0] ADDR_B = 16'h0005,
   parameter int PRE_LEN_B = 3,
   parameter logic [dfir_pkg::BYTE_W*dfir_pkg::PRE_MAX-1:0] PRE_SEQ_B = 32'h0004_4000,
   parameter int OUT_W    = SAMPLE_W + COEF_W + 1 + $clog2(TAPS/2)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_in_a,
   input  logic signed [SAMPLE_W-1:0] smp_in_b,
   output logic                       out_valid,
   output logic signed [OUT_W-1:0]    out_a,
   output logic signed [OUT_W-1:0]    out_b,
   output logic                       preamble_err
);
   localparam int NCH    = 2;
   localparam int HALF   = TAPS / 2;
   localparam int BANK_W = HALF * COEF_W;

   if (ADDR_A == ADDR_B) begin : g_bad_addr
      $error("dfir_dual: channel addresses must differ");
   end

   logic signed [SAMPLE_W-1:0] smp_arr [NCH];
   logic signed [OUT_W-1:0]    y_arr   [NCH];
   logic [BANK_W-1:0]          bank    [NCH];
   logic [NCH-1:0]             err_v, vld_v;
   logic [BANK_W-1:0]          act_a, act_b;

   assign smp_arr[0] = smp_in_a;
   assign smp_arr[1] = smp_in_b;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] MY  = (c == 0) ? ADDR_A : ADDR_B;
      localparam logic [ADDR_W-1:0] OTH = (c == 0) ? ADDR_B : ADDR_A;
      localparam int                PL  = (c == 0) ? 0 : PRE_LEN_B;

      dfir_coef_loader #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_W(COEF_W), .HALF(HALF),
         .MY_ADDR(MY), .OTHER_ADDR(OTH), .PRE_LEN(PL), .PRE_SEQ(PRE_SEQ_B)
      ) u_ld (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
         .wr_data(wr_data), .act_bank(bank[c]), .pre_err(err_v[c])
      );

      dfir_sym_fir #(
         .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS), .OUT_W(OUT_W)
      ) u_fir (
         .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_arr[c]),
         .coef_bank(bank[c]), .out_valid(vld_v[c]), .out_y(y_arr[c])
      );
   end

   assign act_a        = bank[0];
   assign act_b        = bank[1];
   assign out_a        = y_arr[0];
   assign out_b        = y_arr[1];
   assign out_valid    = &vld_v;
   assign preamble_err = |err_v;

endmodule

// File: rtl/dfir_dual_chk.sv
module dfir_dual_chk #(
   parameter int ADDR_W = 16,
   parameter int OUT_W  = 24,
   parameter int BANK_W = 48,
   parameter logic [ADDR_W-1:0] ADDR_A = 16'h0001,
   parameter logic [ADDR_W-1:0] ADDR_B = 16'h0005
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              smp_valid,
   input logic              out_valid,
   input logic [OUT_W-1:0]  out_a,
   input logic [OUT_W-1:0]  out_b,
   input logic              preamble_err,
   input logic [BANK_W-1:0] act_a,
   input logic [BANK_W-1:0] act_b
);

   AST_ERR_FROM_B_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      preamble_err |-> ($past(wr_en) && $past(wr_addr) == ADDR_B)); // R7

   AST_BANK_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(wr_en) && $past(wr_addr) == ADDR_A) |-> $stable(act_a)); // R5

   AST_BANK_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(wr_en) && $past(wr_addr) == ADDR_B) |-> $stable(act_b)); // R5

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(smp_valid, 2)); // R9

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_a) && $stable(out_b))); // R9

endmodule

bind dfir_dual dfir_dual_chk #(
   .ADDR_W(ADDR_W), .OUT_W(OUT_W), .BANK_W(BANK_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .smp_valid(smp_valid), .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
   .preamble_err(preamble_err), .act_a(act_a), .act_b(act_b)
);

// File: tb/dfir_dual_tb.sv
module dfir_dual_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int OUT_W = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        smp_valid = 1'b0;
   logic signed [11:0] smp_in_a = '0;
   logic signed [11:0] smp_in_b = '0;
   logic        out_valid;
   logic signed [OUT_W-1:0] out_a, out_b;
   logic        preamble_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int ca [6];
   int cb [6];
   int ha [12];
   int hb [12];

   always #(CLK_PERIOD/2) clk = ~clk;

   dfir_dual dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .smp_valid(smp_valid), .smp_in_a(smp_in_a), .smp_in_b(smp_in_b),
      .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .preamble_err(preamble_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model(input int c [6], input int h [12]);
      int s = 0;
      for (int k = 0; k < 6; k++) s += c[k] * (h[k] + h[11-k]);
      return s;
   endfunction

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   // Sends one sample pair and checks the result strobe, the values and the hold.
   task automatic send(input int sa, input int sb, input string req);
      int ea, eb;
      logic signed [OUT_W-1:0] qa, qb;
      smp_valid = 1'b1; smp_in_a = 12'(sa); smp_in_b = 12'(sb);
      @(negedge clk);
      smp_valid = 1'b0;
      for (int i = 11; i > 0; i--) begin ha[i] = ha[i-1]; hb[i] = hb[i-1]; end
      ha[0] = sa; hb[0] = sb;
      ea = model(ca, ha); eb = model(cb, hb);
      @(negedge clk);
      chk(out_valid == 1'b1, "R9 strobe", out_valid, 1);
      chk(int'(out_a) == ea, {req, " out_a"}, out_a, ea);
      chk(int'(out_b) == eb, {req, " out_b"}, out_b, eb);
      qa = out_a; qb = out_b;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 single-cycle strobe", out_valid, 0);
      chk(out_a == qa && out_b == qb, "R9 hold", out_a, qa);
   endtask

   task automatic impulse(input string req);
      send(1, 1, req);
      for (int i = 0; i < 12; i++) send(0, 0, req);
   endtask

   task automatic load_a(input int c [6], input logic [7:0] up);
      for (int j = 5; j >= 0; j--) wr(16'h0001, {up, 8'(c[j])});
      ca = c;
   endtask

   task automatic load_b(input int c [6], input logic [7:0] up);
      wr(16'h0005, {up, 8'h04});
      wr(16'h0005, {up, 8'h40});
      wr(16'h0005, {up, 8'h00});
      for (int j = 5; j >= 0; j--) wr(16'h0005, {up, 8'(c[j])});
      cb = c;
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      chk(out_a == 0 && out_b == 0, "R1 outputs", out_a, 0);
      chk(preamble_err == 1'b0, "R1 preamble_err", preamble_err, 0);
      send(1000, -777, "R1 zero coefficients");
      send(0, 0, "R1 zero coefficients");
   endtask

   task automatic t_load_a();
      int c [6] = '{1, 2, 3, 4, 5, 6};
      load_a(c, 8'hA5);   // R4 upper byte junk
      impulse("R2 R4 R8 channel A impulse");
   endtask

   task automatic t_load_b();
      int c [6] = '{-1, -3, 7, -128, 127, 10};
      load_b(c, 8'hFF);   // R4 upper byte junk
      impulse("R3 R8 channel B impulse");
   endtask

   task automatic t_partial();
      int c [6] = '{9, -9, 17, -17, 33, -33};
      for (int j = 5; j >= 2; j--) wr(16'h0001, {8'h00, 8'(c[j])});
      impulse("R5 partial block keeps old A");
      wr(16'h0001, {8'h3C, 8'(c[1])});
      wr(16'h0001, {8'h00, 8'(c[0])});
      ca = c;
      impulse("R11 completed block applies");
   endtask

   task automatic t_bad_pre();
      int c [6] = '{2, 4, 8, 16, 32, 64};
      wr(16'h0005, 16'h0004);
      wr(16'h0005, 16'h0041);
      chk(preamble_err == 1'b1, "R7 flag on bad second byte", preamble_err, 1);
      @(negedge clk);
      chk(preamble_err == 1'b0, "R7 flag one cycle", preamble_err, 0);
      wr(16'h0005, 16'h0007);
      chk(preamble_err == 1'b1, "R7 flag on bad first byte", preamble_err, 1);
      wr(16'h0005, 16'h0004);
      chk(preamble_err == 1'b0, "R7 good byte no flag", preamble_err, 0);
      wr(16'h0005, 16'h0040);
      wr(16'h0005, 16'h0000);
      wr(16'h0005, 16'h00FF);  // a coefficient byte, not a preamble byte: no flag
      chk(preamble_err == 1'b0, "R7 data byte no flag", preamble_err, 0);
      wr(16'h0001, 16'h0000);  // aborts B (R6)
      load_b(c, 8'h12);
      impulse("R7 restart then full B block");
   endtask

   task automatic t_other_addr();
      int c [6] = '{-2, 5, -11, 23, -47, 95};
      for (int j = 5; j >= 0; j--) begin
         wr(16'h0001, {8'h00, 8'(c[j])});
         wr(16'h0002, 16'h0077);
         wr(16'h0101, 16'h0011);
         wr(16'h0000, 16'h0004);
      end
      ca = c;
      impulse("R10 unrelated writes ignored");
   endtask

   task automatic t_abort();
      int x [6] = '{50, 50, 50, 50, 50, 50};
      int y [6] = '{-7, 0, 3, -1, 100, -100};
      int z [6] = '{1, -1, 1, -1, 1, -1};
      wr(16'h0001, {8'h00, 8'(x[5])});
      wr(16'h0001, {8'h00, 8'(x[4])});
      wr(16'h0001, {8'h00, 8'(x[3])});
      wr(16'h0005, 16'h0004);  // aborts A, starts B
      send(300, 300, "R6 aborted A keeps old");
      load_a(y, 8'h00);        // A starts afresh; also aborts B
      load_b(z, 8'h00);
      impulse("R6 fresh blocks after abort");
   endtask

   task automatic t_mixed();
      int v = 37;
      send(2047, -2048, "R8 extreme");
      send(-2048, 2047, "R8 extreme");
      for (int i = 0; i < 20; i++) begin
         v = (v * 1103 + 911) % 4096;
         send(v - 2048, 2047 - v, "R8 mixed");
      end
   endtask

   initial begin
      for (int i = 0; i < 6; i++) begin ca[i] = 0; cb[i] = 0; end
      for (int i = 0; i < 12; i++) begin ha[i] = 0; hb[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_a();
      t_load_b();
      t_partial();
      t_bad_pre();
      t_other_addr();
      t_abort();
      t_mixed();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule